// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each data beat of one SDRAM burst. A controller programs a small mode register that holds the burst length, the ordering (sequential or interleaved) and a write-single option. It then pulses a start request with the first column and a read/write flag. From the next cycle on, the block emits one column per clock. It flags every valid beat and marks the final one, so the controller can drive the data path and issue the following command.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the naturally aligned block of that size that contains the start column. The low address bits wrap within that block and the upper bits hold. Full-page bursts step through all 256 columns, wrapping from the top column to zero, and run until the controller raises a stop request. When write-single is set, every write is a one-beat burst while reads keep the programmed length.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and with no start accepted, `beat_valid_o` and `last_o` are low.
- R2: A start that is accepted at a clock edge makes `beat_valid_o` high in the following cycle, with `col_o` equal to the start column sampled at that edge.
- R3: Length codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. `last_o` is high on the final beat only, and `beat_valid_o` drops in the cycle after it unless a new start was accepted.
- R4: In sequential order, beat n of a fixed burst of length L carries the start column's upper bits unchanged, and its low log2(L) bits equal (start low bits + n) mod L.
- R5: In interleaved order (interleave bit = 1), beat n of a fixed burst has low log2(L) bits equal to the start low bits XOR n, and the upper bits equal the start column's.
- R6: A length code with bit 2 set selects full page. Beat n carries (start + n) mod 256, and the interleave bit has no effect. The burst continues until `stop_i` is seen high during a beat, and `last_o` is high in exactly that beat.
- R7: With write-single set in the mode register, a burst started with `write_i` high has one beat. A burst started with `write_i` low uses the programmed length.
- R8: A start presented during a beat that is not the last has no effect. A start presented during the last beat begins a new burst in the next cycle, with no idle cycle in between.
- R9: The mode register is loaded when `mode_wr_i` is high. A burst uses the mode held when it was accepted, and a load during the burst changes neither its length nor its order.
- R10: In fixed-length bursts, `stop_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wr_i | input | 1 | Load the mode register |
| mode_len_i | input | 3 | Length code: 0..3 give 1/2/4/8 beats, bit 2 set gives full page |
| mode_ilv_i | input | 1 | 1 selects interleaved order, 0 sequential |
| mode_wsingle_i | input | 1 | 1 makes every write a single beat |
| start_i | input | 1 | Burst request |
| start_col_i | input | COL_W | First column of the burst |
| write_i | input | 1 | Request is a write |
| stop_i | input | 1 | Ends a full-page burst in the current beat |
| col_o | output | COL_W | Column of the current beat |
| beat_valid_o | output | 1 | Current beat is valid |
| last_o | output | 1 | Current beat is the final one |

## Verification
The hardest cases to reach from the ports involve starts and mode loads that arrive while a burst is running. Such a start is ignored on a middle beat but begins a new burst at once on the last beat. A mode load must not disturb the burst already in progress. The bench reaches these cases by driving start and mode inputs on chosen beats of a running burst, and it checks that the column sequence continues unchanged or restarts without a gap. Full-page wrap from 255 to 0 is reached by starting near the top column and holding stop low past the boundary.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int LEN_CODE_W = 3;

  typedef struct packed {
    logic [LEN_CODE_W-1:0] len_code;
    logic                  interleave;
    logic                  write_single;
  } burst_mode_t;

  // Any length code with its top bit set selects a full-page burst.
  function automatic logic code_is_full(input logic [LEN_CODE_W-1:0] code);
    return code[LEN_CODE_W-1];
  endfunction
endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import burst_col_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [LEN_CODE_W-1:0] len_i,
  input  logic                  ilv_i,
  input  logic                  wsingle_i,
  output burst_mode_t           mode_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o <= '0;
    end else if (wr_i) begin
      mode_o.len_code     <= len_i;
      mode_o.interleave   <= ilv_i;
      mode_o.write_single <= wsingle_i;
    end
  end
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  burst_mode_t      mode_i,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             write_i,
  input  logic             stop_i,
  output logic             active_o,
  output logic             last_o,
  output logic             accept_o,
  output logic [COL_W-1:0] beat_idx_o,
  output logic [COL_W-1:0] cur_start_o,
  output logic [COL_W-1:0] cur_mask_o,
  output logic             cur_ilv_o,
  output logic             cur_full_o
);
  localparam logic [COL_W-1:0] ONE = {{(COL_W-1){1'b0}}, 1'b1};

  // Mask of the column bits that move inside one burst.
  function automatic logic [COL_W-1:0] span_mask(input logic [LEN_CODE_W-1:0] code);
    if (code_is_full(code)) return '1;
    return (ONE << code[1:0]) - ONE;
  endfunction

  logic             single_w;
  logic             full_w;
  logic [COL_W-1:0] next_mask_w;

  assign single_w    = mode_i.write_single && write_i;
  assign full_w      = code_is_full(mode_i.len_code) && !single_w;
  assign next_mask_w = single_w ? '0 : span_mask(mode_i.len_code);

  assign last_o   = active_o && (cur_full_o ? stop_i : (beat_idx_o == cur_mask_o));
  assign accept_o = start_i && (!active_o || last_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o    <= 1'b0;
      beat_idx_o  <= '0;
      cur_start_o <= '0;
      cur_mask_o  <= '0;
      cur_ilv_o   <= 1'b0;
      cur_full_o  <= 1'b0;
    end else if (accept_o) begin
      active_o    <= 1'b1;
      beat_idx_o  <= '0;
      cur_start_o <= start_col_i;
      cur_mask_o  <= next_mask_w;
      cur_ilv_o   <= mode_i.interleave && !full_w;
      cur_full_o  <= full_w;
    end else if (last_o) begin
      active_o    <= 1'b0;
    end else if (active_o) begin
      beat_idx_o  <= beat_idx_o + ONE;
    end
  end
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] start_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] moved_w;

  assign moved_w = ilv_i ? (start_i ^ beat_i) : (start_i + beat_i);

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = mask_i[b] ? moved_w[b] : start_i[b];
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr_i,
  input  logic [2:0]       mode_len_i,
  input  logic             mode_ilv_i,
  input  logic             mode_wsingle_i,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             write_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_valid_o,
  output logic             last_o
);
  burst_mode_t      mode_w;
  logic             accept_w;
  logic [COL_W-1:0] beat_idx_w;
  logic [COL_W-1:0] cur_start_w;
  logic [COL_W-1:0] cur_mask_w;
  logic             cur_ilv_w;
  logic             cur_full_w;

  burst_mode_reg i_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (mode_wr_i),
    .len_i     (mode_len_i),
    .ilv_i     (mode_ilv_i),
    .wsingle_i (mode_wsingle_i),
    .mode_o    (mode_w)
  );

  burst_beat_ctrl #(.COL_W(COL_W)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_w),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .write_i     (write_i),
    .stop_i      (stop_i),
    .active_o    (beat_valid_o),
    .last_o      (last_o),
    .accept_o    (accept_w),
    .beat_idx_o  (beat_idx_w),
    .cur_start_o (cur_start_w),
    .cur_mask_o  (cur_mask_w),
    .cur_ilv_o   (cur_ilv_w),
    .cur_full_o  (cur_full_w)
  );

  burst_col_map #(.COL_W(COL_W)) i_map (
    .start_i (cur_start_w),
    .beat_i  (beat_idx_w),
    .mask_i  (cur_mask_w),
    .ilv_i   (cur_ilv_w),
    .col_o   (col_o)
  );
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_col_i_unused_guard,
  input logic [COL_W-1:0] start_col_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             beat_valid_o,
  input logic             last_o,
  input logic             accept_w,
  input logic [COL_W-1:0] cur_start_w,
  input logic [COL_W-1:0] cur_mask_w,
  input logic             cur_ilv_w,
  input logic             cur_full_w
);
  localparam logic [COL_W-1:0] ONE = {{(COL_W-1){1'b0}}, 1'b1};

  // R2
  start_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> beat_valid_o && (col_o == $past(start_col_i)));

  // R3
  last_is_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> beat_valid_o);

  // R3
  end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !accept_w) |=> !beat_valid_o);

  // R8
  midburst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !last_o) |=> beat_valid_o && $stable(cur_start_w) && $stable(cur_mask_w));

  // R4
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !last_o && !cur_ilv_w) |=> (((col_o - $past(col_o)) & cur_mask_w) == ONE));

  // R5
  upper_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o |-> (((col_o ^ cur_start_w) & ~cur_mask_w) == '0));

  // R6
  full_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && cur_full_w) |-> (last_o == stop_i));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid_o |-> !last_o);

  logic unused_w;
  assign unused_w = start_col_i_unused_guard;
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) i_chk (
  .clk                      (clk),
  .rst_n                    (rst_n),
  .start_col_i_unused_guard (start_i),
  .start_col_i              (start_col_i),
  .stop_i                   (stop_i),
  .col_o                    (col_o),
  .beat_valid_o             (beat_valid_o),
  .last_o                   (last_o),
  .accept_w                 (accept_w),
  .cur_start_w              (cur_start_w),
  .cur_mask_w               (cur_mask_w),
  .cur_ilv_w                (cur_ilv_w),
  .cur_full_w               (cur_full_w)
);

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wr_i = 1'b0;
  logic [2:0] mode_len_i = '0;
  logic       mode_ilv_i = 1'b0;
  logic       mode_wsingle_i = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic       write_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [7:0] col_o;
  logic       beat_valid_o;
  logic       last_o;

  int tests = 0;
  int fails = 0;

  burst_col_gen #(.COL_W(8)) i_burst_col_gen (
    .clk (clk), .rst_n (rst_n),
    .mode_wr_i (mode_wr_i), .mode_len_i (mode_len_i),
    .mode_ilv_i (mode_ilv_i), .mode_wsingle_i (mode_wsingle_i),
    .start_i (start_i), .start_col_i (start_col_i),
    .write_i (write_i), .stop_i (stop_i),
    .col_o (col_o), .beat_valid_o (beat_valid_o), .last_o (last_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected column, restated as base-plus-offset arithmetic.
  function automatic int exp_col(input int s, input int n, input int code, input bit il);
    int len, base, off;
    if (code >= 4) return (s + n) % 256;
    len  = 1 << code;
    base = s - (s % len);
    off  = s % len;
    if (il) return base + (off ^ n);
    return base + ((off + n) % len);
  endfunction

  task automatic set_mode(input int code, input bit il, input bit ws);
    @(negedge clk);
    mode_wr_i = 1'b1; mode_len_i = 3'(code); mode_ilv_i = il; mode_wsingle_i = ws;
    @(negedge clk);
    mode_wr_i = 1'b0;
  endtask

  // Runs a fixed burst and checks every beat plus the idle cycle after.
  task automatic run_fixed(input string req, input int s, input int code, input bit il,
                           input bit wr, input int len, input bit noise);
    @(negedge clk);
    start_i = 1'b1; start_col_i = 8'(s); write_i = wr;
    @(negedge clk);
    start_i = 1'b0;
    for (int b = 0; b < len; b++) begin
      stop_i = noise & b[0];
      #1;
      check(req, int'(beat_valid_o), 1);
      check(req, int'(col_o), exp_col(s, b, (len == 1) ? 0 : code, il));
      check(req, int'(last_o), int'(b == len - 1));
      @(negedge clk);
    end
    stop_i = 1'b0;
    #1;
    check(req, int'(beat_valid_o), 0);
  endtask

  task automatic run_full(input int s, input bit il, input int nbeats);
    @(negedge clk);
    start_i = 1'b1; start_col_i = 8'(s); write_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    for (int b = 0; b < nbeats; b++) begin
      stop_i = (b == nbeats - 1);
      #1;
      check("R6 full col", int'(col_o), (s + b) % 256);
      check("R6 full last", int'(last_o), int'(b == nbeats - 1));
      @(negedge clk);
    end
    stop_i = 1'b0;
    #1;
    check("R6 full end", int'(beat_valid_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset valid", int'(beat_valid_o), 0);
    check("R1 reset last", int'(last_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check("R1 idle valid", int'(beat_valid_o), 0);

    // R3 R4 R5 R10: sweep every start column for every fixed length and order.
    for (int code = 0; code < 4; code++) begin
      for (int il = 0; il < 2; il++) begin
        set_mode(code, il[0], 1'b0);
        for (int s = 0; s < 256; s++)
          run_fixed(il ? "R5 ilv" : "R4 seq", s, code, il[0], 1'b0, 1 << code, s[0]);
      end
    end

    // R6: full page, interleave ignored, wrap over 255 to 0.
    set_mode(7, 1'b1, 1'b0);
    run_full(250, 1'b1, 12);
    run_full(0, 1'b1, 1);
    set_mode(4, 1'b0, 1'b0);
    run_full(128, 1'b0, 300);

    // R7: write single vs read burst.
    set_mode(3, 1'b0, 1'b1);
    run_fixed("R7 write single", 8'h35, 3, 1'b0, 1'b1, 1, 1'b0);
    run_fixed("R7 read burst", 8'h35, 3, 1'b0, 1'b0, 8, 1'b0);
    set_mode(7, 1'b0, 1'b1);
    run_fixed("R7 write single full", 8'hFE, 0, 1'b0, 1'b1, 1, 1'b1);
    set_mode(2, 1'b1, 1'b0);
    run_fixed("R7 write no single", 8'h12, 2, 1'b1, 1'b1, 4, 1'b0);

    // R8: start on a middle beat is ignored.
    set_mode(3, 1'b0, 1'b0);
    @(negedge clk);
    start_i = 1'b1; start_col_i = 8'h13;
    @(negedge clk);
    start_i = 1'b0;
    for (int b = 0; b < 8; b++) begin
      if (b == 2) begin start_i = 1'b1; start_col_i = 8'h80; end
      else start_i = 1'b0;
      #1;
      check("R8 ignore mid", int'(col_o), exp_col(8'h13, b, 3, 1'b0));
      check("R8 ignore last", int'(last_o), int'(b == 7));
      @(negedge clk);
    end
    start_i = 1'b0;
    #1;
    check("R8 ignore end", int'(beat_valid_o), 0);

    // R8: start on the last beat chains without a gap.
    set_mode(1, 1'b0, 1'b0);
    @(negedge clk);
    start_i = 1'b1; start_col_i = 8'h21;
    @(negedge clk);
    start_i = 1'b0;
    #1;
    check("R8 chain b0", int'(col_o), 8'h21);
    @(negedge clk);
    start_i = 1'b1; start_col_i = 8'h44;
    #1;
    check("R8 chain b1", int'(col_o), 8'h20);
    check("R8 chain last", int'(last_o), 1);
    @(negedge clk);
    start_i = 1'b0;
    #1;
    check("R8 chain valid", int'(beat_valid_o), 1);
    check("R8 chain new col", int'(col_o), 8'h44);
    @(negedge clk);
    #1;
    check("R8 chain new b1", int'(col_o), 8'h45);
    @(negedge clk);
    #1;
    check("R8 chain done", int'(beat_valid_o), 0);

    // R9: mode load during a burst does not disturb it.
    set_mode(2, 1'b0, 1'b0);
    @(negedge clk);
    start_i = 1'b1; start_col_i = 8'h05;
    @(negedge clk);
    start_i = 1'b0;
    for (int b = 0; b < 4; b++) begin
      mode_wr_i = (b == 1); mode_len_i = 3'd0; mode_ilv_i = 1'b1;
      #1;
      check("R9 held col", int'(col_o), exp_col(5, b, 2, 1'b0));
      check("R9 held last", int'(last_o), int'(b == 3));
      @(negedge clk);
    end
    mode_wr_i = 1'b0;
    run_fixed("R9 new mode", 8'h05, 0, 1'b1, 1'b0, 1, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule